// File: doc/BRIEF.md
# Double-Buffered Serial Port with Shift Mode

This block is a full-duplex serial port for a microcontroller subsystem. Software sees two byte locations: a control/status register and a data location. A write to the data location hands a byte to the transmitter and starts a frame. A read of the same location returns a separate receive holding register, so the two directions never share storage. The receiver keeps one completed byte in the holding register while a new frame shifts into its own shift register. This lets a second frame arrive before software has collected the first.

The two low control bits select one of four formats. Mode 0 is a synchronous shifter: it moves eight bits out, or in, least significant bit first, next to a shift clock that it drives itself. Mode 1 is an asynchronous 8-bit frame. Mode 2 is an asynchronous 9-bit frame at a fixed rate taken from the system clock. Mode 3 is an asynchronous 9-bit frame at a variable rate. In modes 1 and 3 the bit rate comes from an external timer overflow pulse. Each pulse is one sixteenth of a bit time.

The asynchronous receiver oversamples every bit 16 times and decides each bit by a majority vote of three samples at the centre of the bit. Completion flags are set by hardware and stay set until software writes them to zero.

Top module: `serial_port`

## Requirements
- R1: After reset, txd_out, sclk_out and sdata_out are 1, and both the control register and the receive holding register read 0.
- R2: In modes 1 and 3, each bit lasts 16 oversample ticks, and each oversample tick is one baud_tick pulse. The transmitter sends a start bit of 0, then eight data bits least significant bit first, then a stop bit of 1. The start bit drives txd_out in the cycle after the write that started the frame.
- R3: In modes 2 and 3, a ninth bit follows the eight data bits. Control bit 3 supplies the ninth bit on transmit. The ninth bit of an accepted received frame is stored in control bit 4.
- R4: In mode 2, the oversample tick comes from an internal divider, one tick every FIX_DIV clocks. A bit therefore lasts 16*FIX_DIV clocks, and baud_tick has no effect.
- R5: Control bit 5 (transmit done) is set when a frame ends. Control bit 6 (receive done) is set when a received frame ends. Each flag stays set until a control write puts a 0 in its position. If hardware sets a flag in the same cycle as such a write, the set wins.
- R6: A write to the data location while a transmission (or a shift-mode transfer) is in progress is ignored. No second frame is sent.
- R7: A read of the data location returns the receive holding register. A write to the data location does not change what is read back.
- R8: The receive holding register is loaded only when a frame ends while receive done is clear. If receive done is still set when a second frame ends, the second byte is dropped and the first byte is kept. If software clears the flag while the second frame is arriving, the second byte is loaded.
- R9: Each received bit takes the majority value of the 7th, 8th and 9th of its 16 oversamples. A disturbance one tick wide at the centre of a bit does not change the received value.
- R10: If the start bit votes 1, reception is abandoned (false start). A frame whose stop bit votes 0 is discarded. In both cases receive done is not set and the holding register is unchanged.
- R11: The asynchronous receiver starts a frame only when control bit 2 (receive enable) is 1 and the mode is not 0.
- R12: In mode 0, a data write shifts the byte out least significant bit first on sdata_out. For each bit, sclk_out is low for SYNC_DIV/2 clocks and then high for SYNC_DIV/2 clocks. The data bit is valid while sclk_out is high, and transmit done is set after the eighth bit.
- R13: In mode 0, a control write of mode 0 with receive enable 1 and receive done 0 starts an 8-bit shift-in. The shift-in samples rxd_in (through a two-stage synchronizer) as sclk_out rises, least significant bit first, then loads the holding register and sets receive done.
- R14: In the asynchronous modes, transmission and reception run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel_data | input | 1 | 0 selects the control register, 1 selects the data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected location (combinational) |
| baud_tick | input | 1 | Timer overflow pulse, one oversample tick in modes 1 and 3 |
| rxd_in | input | 1 | Serial receive line (asynchronous frames, or shift-mode data in) |
| txd_out | output | 1 | Asynchronous transmit line, idle 1 |
| sclk_out | output | 1 | Shift clock in mode 0, idle 1 |
| sdata_out | output | 1 | Shift-mode data out, idle 1 |

## Verification
The checker watches, on every cycle, the invariants that hold across time. The idle levels of the serial lines stay at 1. The start bit appears when the transmitter becomes busy. A frame end always leaves its completion flag set. The holding register moves only on an accepted frame, and never while a full register is holding a byte. The two transmit engines are never busy together. Other behaviour is visible only from the bench's stimulus and decoding at the pins:
- the bit order and frame length in each mode;
- the ninth-bit path;
- the fixed-rate timing with baud_tick stopped;
- majority filtering of a narrow glitch;
- false starts and framing errors;
- the drop-versus-load outcome of the double buffer;
- ignored data writes while busy;
- concurrent traffic in both directions.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_A8_VAR = 2'd1,
    MODE_A9_FIX = 2'd2,
    MODE_A9_VAR = 2'd3
  } sp_mode_e;

  // majority of three oversamples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // total bits on the line for one asynchronous frame
  function automatic logic [3:0] frame_bits(input logic nine);
    return nine ? 4'd11 : 4'd10;
  endfunction

  // modes 2 and 3 carry a ninth bit
  function automatic logic has_nine(input sp_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen #(
  parameter int FIX_DIV = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  serial_port_pkg::sp_mode_e   mode,
  input  logic                        ext_tick,
  output logic                        os_tick
);
  import serial_port_pkg::*;

  localparam int CW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

  logic          fix_tick;
  logic [CW-1:0] div_q;

  generate
    if (FIX_DIV > 1) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           div_q <= '0;
        else if (div_q == CW'(FIX_DIV - 1))   div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign fix_tick = (div_q == CW'(FIX_DIV - 1));
    end else begin : g_nodiv
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= '0;
      end
      assign fix_tick = 1'b1;
    end
  endgenerate

  assign os_tick = (mode == MODE_A9_FIX) ? fix_tick : ext_tick;

endmodule

// File: rtl/sp_tx_async.sv
module sp_tx_async #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       nine,
  input  logic       bit8,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  import serial_port_pkg::*;

  localparam int SW = $clog2(OVS);

  logic [10:0]   sh_q;
  logic [SW-1:0] sub_q;
  logic [3:0]    left_q;
  logic          bit_end;

  assign bit_end = busy && tick && (sub_q == SW'(OVS - 1));
  assign done    = bit_end && (left_q == 4'd1);
  assign txd     = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh_q   <= '1;
      sub_q  <= '0;
      left_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        sh_q   <= {1'b1, (nine ? bit8 : 1'b1), din, 1'b0};
        sub_q  <= '0;
        left_q <= frame_bits(nine);
      end
    end else if (tick) begin
      if (bit_end) begin
        sub_q  <= '0;
        sh_q   <= {1'b1, sh_q[10:1]};
        left_q <= left_q - 1'b1;
        if (left_q == 4'd1) busy <= 1'b0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sp_rx_async.sv
module sp_rx_async #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       arm,
  input  logic       nine,
  input  logic       rxd,
  output logic       busy,
  output logic       done,
  output logic [7:0] data,
  output logic       bit8
);
  import serial_port_pkg::*;

  localparam int SW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;

  logic [SW-1:0] sub_q;
  logic [3:0]    idx_q;
  logic [2:0]    vote_q;
  logic [7:0]    sh_q;
  logic          b8_q;
  logic          bitv;
  logic          bit_end;
  logic [3:0]    last_idx;

  assign bitv     = vote3(vote_q);
  assign last_idx = nine ? 4'd10 : 4'd9;
  assign bit_end  = busy && tick && (sub_q == SW'(OVS - 1));
  assign done     = bit_end && (idx_q == last_idx) && bitv;
  assign data     = sh_q;
  assign bit8     = b8_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      vote_q <= '0;
      sh_q   <= '0;
      b8_q   <= 1'b0;
    end else if (!busy) begin
      if (tick && arm && !rxd) begin
        busy  <= 1'b1;
        sub_q <= SW'(1);
        idx_q <= '0;
      end
    end else if (tick) begin
      if (bit_end) begin
        sub_q <= '0;
        idx_q <= idx_q + 1'b1;
        if (idx_q == 4'd0) begin
          if (bitv) busy <= 1'b0;
        end else if (idx_q <= 4'd8) begin
          sh_q <= {bitv, sh_q[7:1]};
        end else if (idx_q == 4'd9 && nine) begin
          b8_q <= bitv;
        end
        if (idx_q == last_idx) busy <= 1'b0;
      end else begin
        if (sub_q >= SW'(MID) && sub_q <= SW'(MID + 2))
          vote_q[sub_q - SW'(MID)] <= rxd;
        sub_q <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sp_sync_shift.sv
module sp_sync_shift #(
  parameter int SYNC_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_start,
  input  logic       rx_start,
  input  logic [7:0] din,
  input  logic       rxd,
  output logic       sclk,
  output logic       sdo,
  output logic       busy,
  output logic       tx_done,
  output logic       rx_done,
  output logic [7:0] dout
);
  localparam int PW   = (SYNC_DIV > 2) ? $clog2(SYNC_DIV) : 1;
  localparam int HALF = SYNC_DIV / 2;

  logic          dir_rx_q;
  logic [PW-1:0] ph_q;
  logic [2:0]    cnt_q;
  logic [7:0]    sh_q;
  logic          bit_end;

  assign bit_end = busy && (ph_q == PW'(SYNC_DIV - 1));
  assign tx_done = bit_end && !dir_rx_q && (cnt_q == 3'd7);
  assign rx_done = bit_end &&  dir_rx_q && (cnt_q == 3'd7);
  assign sclk    = !busy || (ph_q >= PW'(HALF));
  assign sdo     = (busy && !dir_rx_q) ? sh_q[0] : 1'b1;
  assign dout    = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dir_rx_q <= 1'b0;
      ph_q     <= '0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (!busy) begin
      if (tx_start || rx_start) begin
        busy     <= 1'b1;
        dir_rx_q <= rx_start;
        ph_q     <= '0;
        cnt_q    <= '0;
        sh_q     <= rx_start ? 8'h00 : din;
      end
    end else begin
      if (dir_rx_q && ph_q == PW'(HALF))
        sh_q <= {rxd, sh_q[7:1]};
      if (bit_end) begin
        ph_q  <= '0;
        cnt_q <= cnt_q + 1'b1;
        if (!dir_rx_q) sh_q <= {1'b1, sh_q[7:1]};
        if (cnt_q == 3'd7) busy <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_port.sv
module serial_port #(
  parameter int FIX_DIV  = 2,
  parameter int SYNC_DIV = 4,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_sel_data,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       baud_tick,
  input  logic       rxd_in,
  output logic       txd_out,
  output logic       sclk_out,
  output logic       sdata_out
);
  import serial_port_pkg::*;

  // control register state
  sp_mode_e   mode_q;
  logic       rx_en_q, tx_b8_q, rx_b8_q, tx_done_q, rx_done_q;
  logic [7:0] rx_hold;

  // two-stage input synchronizer
  logic [1:0] rx_sync_q;
  logic       rxs;

  // named events between pieces
  logic       wr_ctrl, wr_data;
  logic       os_tick, nine;
  logic       atx_busy, atx_done;
  logic       arx_busy, arx_done, arx_b8;
  logic [7:0] arx_data;
  logic       stx_busy, stx_tx_done, stx_rx_done;
  logic [7:0] stx_data;
  logic       tx_accept, go_async_tx, go_sync_tx, go_sync_rx;
  logic       tx_evt, rx_evt, rx_load;
  logic [7:0] rx_word;

  assign wr_ctrl     = bus_wr && !bus_sel_data;
  assign wr_data     = bus_wr &&  bus_sel_data;
  assign nine        = has_nine(mode_q);
  assign tx_accept   = wr_data && !atx_busy && !stx_busy;
  assign go_async_tx = tx_accept && (mode_q != MODE_SHIFT);
  assign go_sync_tx  = tx_accept && (mode_q == MODE_SHIFT);
  assign go_sync_rx  = wr_ctrl && (bus_wdata[1:0] == 2'd0) && bus_wdata[2]
                       && !bus_wdata[6] && !stx_busy;
  assign tx_evt      = atx_done | stx_tx_done;
  assign rx_evt      = arx_done | stx_rx_done;
  assign rx_word     = arx_done ? arx_data : stx_data;
  assign rx_load     = rx_evt && !rx_done_q;
  assign rxs         = rx_sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync_q <= 2'b11;
    else        rx_sync_q <= {rx_sync_q[0], rxd_in};
  end

  sp_tick_gen #(.FIX_DIV(FIX_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .ext_tick(baud_tick), .os_tick(os_tick)
  );

  sp_tx_async #(.OVS(OVS)) u_atx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .start(go_async_tx),
    .din(bus_wdata), .nine(nine), .bit8(tx_b8_q),
    .txd(txd_out), .busy(atx_busy), .done(atx_done)
  );

  sp_rx_async #(.OVS(OVS)) u_arx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick),
    .arm(rx_en_q && (mode_q != MODE_SHIFT)), .nine(nine), .rxd(rxs),
    .busy(arx_busy), .done(arx_done), .data(arx_data), .bit8(arx_b8)
  );

  sp_sync_shift #(.SYNC_DIV(SYNC_DIV)) u_sync (
    .clk(clk), .rst_n(rst_n), .tx_start(go_sync_tx), .rx_start(go_sync_rx),
    .din(bus_wdata), .rxd(rxs), .sclk(sclk_out), .sdo(sdata_out),
    .busy(stx_busy), .tx_done(stx_tx_done), .rx_done(stx_rx_done),
    .dout(stx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_SHIFT;
      rx_en_q   <= 1'b0;
      tx_b8_q   <= 1'b0;
      rx_b8_q   <= 1'b0;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rx_hold   <= 8'h00;
    end else begin
      if (wr_ctrl) begin
        mode_q  <= sp_mode_e'(bus_wdata[1:0]);
        rx_en_q <= bus_wdata[2];
        tx_b8_q <= bus_wdata[3];
      end
      tx_done_q <= (wr_ctrl ? bus_wdata[5] : tx_done_q) | tx_evt;
      rx_done_q <= (wr_ctrl ? bus_wdata[6] : rx_done_q) | rx_evt;
      if (rx_load) begin
        rx_hold <= rx_word;
        if (arx_done && nine) rx_b8_q <= arx_b8;
        else if (wr_ctrl)     rx_b8_q <= bus_wdata[4];
      end else if (wr_ctrl) begin
        rx_b8_q <= bus_wdata[4];
      end
    end
  end

  assign bus_rdata = bus_sel_data ? rx_hold
                   : {1'b0, rx_done_q, tx_done_q, rx_b8_q, tx_b8_q, rx_en_q, mode_q};

endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       atx_busy,
  input logic       stx_busy,
  input logic       txd_out,
  input logic       sclk_out,
  input logic       tx_evt,
  input logic       rx_evt,
  input logic       tx_done_q,
  input logic       rx_done_q,
  input logic       rx_load,
  input logic [7:0] rx_hold
);

  // R2: line idles high between frames
  a_r2_txd_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !atx_busy |-> txd_out);

  // R2: the first bit on the line is the start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(atx_busy) |-> !txd_out);

  // R12: shift clock idles high
  a_r12_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !stx_busy |-> sclk_out);

  // R5: a frame end leaves transmit done set
  a_r5_tx_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> tx_done_q);

  // R5: a frame end leaves receive done set
  a_r5_rx_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> rx_done_q);

  // R8: the holding register only moves on an accepted frame
  a_r8_hold_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_load |=> $stable(rx_hold));

  // R8: a full holding register is never overwritten
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && rx_done_q) |=> $stable(rx_hold));

  // R6: only one transmit engine is active at a time
  a_r6_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
    !(atx_busy && stx_busy));

endmodule

bind serial_port serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .atx_busy(atx_busy), .stx_busy(stx_busy),
  .txd_out(txd_out), .sclk_out(sclk_out), .tx_evt(tx_evt), .rx_evt(rx_evt),
  .tx_done_q(tx_done_q), .rx_done_q(rx_done_q), .rx_load(rx_load),
  .rx_hold(rx_hold)
);

// File: tb/serial_port_tb.sv
`timescale 1ns/1ps
module serial_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_sel_data = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick = 1'b0;
  logic       rxd_in = 1'b1;
  logic       txd_out, sclk_out, sdata_out;

  int checks = 0;
  int fails  = 0;
  logic [8:0] txq[$];
  int   bitclk = 64;
  bit   nine_m = 1'b0;
  bit   mon_sync = 1'b0;
  bit   tick_en = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_data(bus_sel_data),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
    .rxd_in(rxd_in), .txd_out(txd_out), .sclk_out(sclk_out), .sdata_out(sdata_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel_data = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel_data = sel;
    #0.5 d = bus_rdata;
  endtask

  task automatic send_tx(input logic [7:0] d, input logic b8);
    txq.push_back({b8, d});
    wr(1'b1, d);
  endtask

  task automatic wait_flag(input int pos, input string req);
    logic [7:0] c;
    int n;
    n = 0;
    c = 8'h00;
    while (n < 4000) begin
      rd(1'b0, c);
      if (c[pos]) break;
      n++;
    end
    check(req, c[pos], 1);
  endtask

  task automatic idle_bits(input int nb, input int bclk);
    repeat (nb * bclk) @(negedge clk);
  endtask

  // drive one asynchronous frame; glitch_at selects a bit index to disturb
  task automatic drive_rx(input logic [7:0] d, input logic b8, input bit nine,
                          input int bclk, input logic stopv, input int glitch_at);
    logic [10:0] fr;
    int nb;
    fr = nine ? {stopv, b8, d, 1'b0} : {1'b1, stopv, d, 1'b0};
    nb = nine ? 11 : 10;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rxd_in = fr[i];
      if (i == glitch_at) begin
        repeat (33) @(negedge clk);
        rxd_in = ~fr[i];
        repeat (4) @(negedge clk);
        rxd_in = fr[i];
        repeat (bclk - 38) @(negedge clk);
      end else begin
        repeat (bclk - 1) @(negedge clk);
      end
    end
    rxd_in = 1'b1;
    idle_bits(1, bclk);
  endtask

  // baud tick every 4 clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = tick_en;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // monitor: asynchronous transmit frames
  initial begin
    logic [8:0] got, exp;
    logic st, sp;
    forever begin
      @(negedge clk);
      if (rst_n && !mon_sync && txd_out == 1'b0) begin
        repeat (bitclk / 2) @(negedge clk);
        st = txd_out;
        got = '0;
        for (int i = 0; i < 8; i++) begin
          repeat (bitclk) @(negedge clk);
          got[i] = txd_out;
        end
        if (nine_m) begin
          repeat (bitclk) @(negedge clk);
          got[8] = txd_out;
        end
        repeat (bitclk) @(negedge clk);
        sp = txd_out;
        check("R2 start bit", st, 0);
        check("R2 stop bit", sp, 1);
        if (txq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 unexpected frame actual=%0h expected=none", got);
        end else begin
          exp = txq.pop_front();
          if (!nine_m) exp[8] = 1'b0;
          check(nine_m ? "R3 nine-bit frame" : "R2 frame data", got, exp);
        end
      end
    end
  end

  // monitor: shift-mode transmit
  initial begin
    logic [7:0] got;
    logic [8:0] exp;
    forever begin
      @(negedge clk);
      if (rst_n && mon_sync && !sclk_out) begin
        for (int i = 0; i < 8; i++) begin
          while (sclk_out) @(negedge clk);
          while (!sclk_out) @(negedge clk);
          got[i] = sdata_out;
        end
        if (txq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R12 unexpected shift actual=%0h expected=none", got);
        end else begin
          exp = txq.pop_front();
          check("R12 shift data", got, exp[7:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 txd idle", txd_out, 1);
    check("R1 sclk idle", sclk_out, 1);
    check("R1 sdata idle", sdata_out, 1);
    rd(1'b0, v); check("R1 ctrl reset", v, 8'h00);
    rd(1'b1, v); check("R1 hold reset", v, 8'h00);

    // mode 1, receive enabled
    bitclk = 64; nine_m = 1'b0;
    wr(1'b0, 8'h05);
    send_tx(8'hA5, 1'b0);
    wait_flag(5, "R5 tx done sets");
    idle_bits(2, 64);
    rd(1'b0, v); check("R5 tx done holds", v[5], 1);
    wr(1'b0, 8'h05);
    rd(1'b0, v); check("R5 tx done cleared by write", v[5], 0);

    // R6 write while busy is ignored
    send_tx(8'h3C, 1'b0);
    wr(1'b1, 8'hFF);
    wait_flag(5, "R6 tx done");
    idle_bits(3, 64);
    check("R6 no extra frame queued", txq.size(), 0);
    wr(1'b0, 8'h05);

    // receive and data separation
    drive_rx(8'h96, 1'b0, 1'b0, 64, 1'b1, -1);
    rd(1'b0, v); check("R5 rx done sets", v[6], 1);
    rd(1'b1, v); check("R2 rx data", v, 8'h96);
    send_tx(8'h11, 1'b0);
    rd(1'b1, v); check("R7 read unaffected by data write", v, 8'h96);
    wait_flag(5, "R7 tx done");
    wr(1'b0, 8'h05);

    // R9 majority filter
    drive_rx(8'hFF, 1'b0, 1'b0, 64, 1'b1, 4);
    rd(1'b1, v); check("R9 glitch filtered", v, 8'hFF);
    wr(1'b0, 8'h05);

    // R10 false start and framing error
    @(negedge clk); rxd_in = 1'b0;
    repeat (16) @(negedge clk); rxd_in = 1'b1;
    idle_bits(12, 64);
    rd(1'b0, v); check("R10 false start ignored", v[6], 0);
    drive_rx(8'h0F, 1'b0, 1'b0, 64, 1'b0, -1);
    rd(1'b0, v); check("R10 framing error discarded", v[6], 0);
    rd(1'b1, v); check("R10 hold kept", v, 8'hFF);
    drive_rx(8'h5A, 1'b0, 1'b0, 64, 1'b1, -1);
    rd(1'b1, v); check("R10 recovers", v, 8'h5A);

    // R11 receive disabled
    wr(1'b0, 8'h01);
    drive_rx(8'h33, 1'b0, 1'b0, 64, 1'b1, -1);
    rd(1'b0, v); check("R11 no rx when disabled", v[6], 0);
    rd(1'b1, v); check("R11 hold unchanged", v, 8'h5A);

    // R8 double buffer: second byte dropped while full
    wr(1'b0, 8'h05);
    drive_rx(8'hC3, 1'b0, 1'b0, 64, 1'b1, -1);
    drive_rx(8'h3C, 1'b0, 1'b0, 64, 1'b1, -1);
    rd(1'b1, v); check("R8 first byte kept", v, 8'hC3);
    // R8 second frame lands if flag cleared during its reception
    wr(1'b0, 8'h05);
    drive_rx(8'h11, 1'b0, 1'b0, 64, 1'b1, -1);
    fork
      drive_rx(8'h22, 1'b0, 1'b0, 64, 1'b1, -1);
      begin
        idle_bits(3, 64);
        rd(1'b1, v); check("R8 first byte readable mid-frame", v, 8'h11);
        wr(1'b0, 8'h05);
      end
    join
    rd(1'b1, v); check("R8 second byte loaded", v, 8'h22);
    rd(1'b0, v); check("R8 rx done set again", v[6], 1);

    // R3 mode 3 nine-bit variable rate
    nine_m = 1'b1;
    wr(1'b0, 8'h0F);
    send_tx(8'h81, 1'b1);
    wait_flag(5, "R3 tx done");
    idle_bits(1, 64);
    drive_rx(8'h42, 1'b1, 1'b1, 64, 1'b1, -1);
    rd(1'b0, v); check("R3 rx ninth bit one", v[4], 1);
    rd(1'b1, v); check("R3 rx data", v, 8'h42);
    wr(1'b0, 8'h07);
    drive_rx(8'h24, 1'b0, 1'b1, 64, 1'b1, -1);
    rd(1'b0, v); check("R3 rx ninth bit zero", v[4], 0);

    // R4 mode 2 fixed rate, external tick stopped
    tick_en = 1'b0; bitclk = 32;
    wr(1'b0, 8'h06);
    send_tx(8'h6B, 1'b0);
    wait_flag(5, "R4 tx done");
    idle_bits(2, 32);
    drive_rx(8'hD4, 1'b1, 1'b1, 32, 1'b1, -1);
    rd(1'b1, v); check("R4 fixed-rate rx", v, 8'hD4);
    tick_en = 1'b1; bitclk = 64; nine_m = 1'b0;

    // R14 concurrent transfer
    wr(1'b0, 8'h05);
    fork
      send_tx(8'h99, 1'b0);
      drive_rx(8'hE7, 1'b0, 1'b0, 64, 1'b1, -1);
    join
    wait_flag(5, "R14 tx done");
    rd(1'b1, v); check("R14 rx during tx", v, 8'hE7);
    idle_bits(2, 64);

    // R12 shift-mode transmit
    mon_sync = 1'b1;
    wr(1'b0, 8'h00);
    send_tx(8'hB2, 1'b0);
    wait_flag(5, "R12 tx done");
    repeat (8) @(negedge clk);
    check("R12 sclk idle after", sclk_out, 1);
    check("R12 queue drained", txq.size(), 0);
    mon_sync = 1'b0;

    // R13 shift-mode receive
    begin
      logic [7:0] pat;
      pat = 8'h5D;
      rxd_in = pat[0];
      wr(1'b0, 8'h04);
      for (int i = 0; i < 8; i++) begin
        while (sclk_out) @(negedge clk);
        rxd_in = pat[i];
        while (!sclk_out) @(negedge clk);
      end
      rxd_in = 1'b1;
      wait_flag(6, "R13 rx done");
      rd(1'b1, v); check("R13 shift rx data", v, pat);
    end

    repeat (20) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule